// File: doc/BRIEF.md
# Push-Button Press Pulser with Hold-Off

This block turns a raw, asynchronous push-button level into exactly one single-cycle pulse per press. The button level is first retimed into the system clock domain through a chain of flip-flops. The first rising transition seen on the retimed level fires the pulse at once. The block then stops taking edges for a programmable number of clock cycles, so that contact bounce cannot produce extra pulses.

A lockout flag is high for the whole hold-off window. The window starts in the cycle that carries the pulse. The edge detector keeps tracking the retimed level while the window is open. As a result, a button that is still held down when the window closes does not fire again. The button is only ever used as data and never as a clock. There is no data stream here, so every pin is a plain level with no handshake.

Top module: `btn_press_pulser`

## Requirements
- R1: The raw input is retimed through SYNC_STAGES flip-flops (default 2). A rising change of `btn_raw` that is set up before clock edge k produces `press_pulse` high in the cycle that follows edge k+SYNC_STAGES, which is edge k+2 by default.
- R2: `press_pulse` is high for exactly one clock cycle per accepted press.
- R3: A rising transition whose retimed edge arrives while `lockout` is high produces no pulse.
- R4: `lockout` falls HOLD_CYCLES cycles after the pulse. A retimed rising edge that arrives once `lockout` is low is accepted. With a one-cycle press followed by a second press d cycles later, the second press pulses if and only if d >= HOLD_CYCLES+1.
- R5: A high glitch on `btn_raw` that lasts a single clock cycle counts as a valid press and produces a pulse.
- R6: If the input is still high when the hold-off ends, no pulse follows. A new pulse needs a fresh low-to-high transition.
- R7: `lockout` is high for exactly HOLD_CYCLES consecutive cycles. The first of these cycles is the cycle in which `press_pulse` is high.
- R8: Synchronous active-high `rst` clears the retiming stages, the edge history, the hold-off count and the pulse. Both outputs are low in the cycle after reset is sampled, even in the middle of a window. After reset, a press is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register uses it |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Asynchronous button level, high while pressed |
| press_pulse | output | 1 | One-cycle pulse per accepted press |
| lockout | output | 1 | High while the hold-off window is open |

## Verification
The bench builds the block with HOLD_CYCLES = 6 and the default two retiming stages. The window is therefore short enough that the spacing of a second press can be swept across every value from 2 cycles up to several cycles past rearm. This places the exact boundary d = HOLD_CYCLES+1 between a rejected and an accepted second press inside the sweep. The small window also lets the bench check every cycle of the lockout window, run a bounce train that ends inside the window, hold the button across the window's end, and apply a reset in the middle of a window, all within a few hundred cycles.

// File: rtl/btn_press_pkg.sv
package btn_press_pkg;

  // Width needed to hold the values 0..n.
  function automatic int unsigned count_width(int unsigned n);
    int unsigned w;
    w = $clog2(n + 1);
    return (w < 1) ? 1 : w;
  endfunction

  localparam int unsigned DEFAULT_HOLD   = 16;
  localparam int unsigned DEFAULT_STAGES = 2;

endpackage

// File: rtl/btn_retimer.sv
module btn_retimer #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= 1'b0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/btn_rise_detect.sv
module btn_rise_detect (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic armed,
  output logic rise
);
  logic prev_q;

  // History keeps tracking while disarmed, so a level held high
  // through the window never looks like a new edge.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign rise = armed & level & ~prev_q;
endmodule

// File: rtl/btn_holdoff.sv
module btn_holdoff #(
  parameter int unsigned HOLD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int unsigned CW = btn_press_pkg::count_width(HOLD);
  localparam logic [CW-1:0] LOAD = CW'(HOLD);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst)                  remain_q <= '0;
    else if (start)           remain_q <= LOAD;
    else if (remain_q != '0)  remain_q <= remain_q - 1'b1;
  end

  assign busy = (remain_q != '0);
endmodule

// File: rtl/btn_press_pulser.sv
module btn_press_pulser #(
  parameter int unsigned HOLD_CYCLES = btn_press_pkg::DEFAULT_HOLD,
  parameter int unsigned SYNC_STAGES = btn_press_pkg::DEFAULT_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic press_pulse,
  output logic lockout
);
  logic btn_s;
  logic edge_seen;
  logic busy;
  logic pulse_q;

  btn_retimer #(.STAGES(SYNC_STAGES)) u_retime (
    .clk     (clk),
    .rst     (rst),
    .d_async (btn_raw),
    .q_sync  (btn_s)
  );

  btn_rise_detect u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (btn_s),
    .armed (~busy),
    .rise  (edge_seen)
  );

  btn_holdoff #(.HOLD(HOLD_CYCLES)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .start (edge_seen),
    .busy  (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= edge_seen;
  end

  assign press_pulse = pulse_q;
  assign lockout     = busy;
endmodule

// File: rtl/btn_press_pulser_chk.sv
module btn_press_pulser_chk #(
  parameter int unsigned HOLD_CYCLES = 16
) (
  input logic clk,
  input logic rst,
  input logic press_pulse,
  input logic lockout
);
  localparam int unsigned RW = btn_press_pkg::count_width(HOLD_CYCLES) + 1;
  logic [RW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)          run_len <= '0;
    else if (lockout) run_len <= run_len + 1'b1;
    else              run_len <= '0;
  end

  // R2: a pulse never lasts two cycles
  assert_single_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    press_pulse |=> !press_pulse);

  // R7: the pulse cycle is the first cycle of the window
  assert_pulse_opens_window_R7: assert property (@(posedge clk) disable iff (rst)
    press_pulse |-> lockout);

  // R3: no pulse while the window was already open
  assert_no_pulse_in_window_R3: assert property (@(posedge clk) disable iff (rst)
    press_pulse |-> !$past(lockout));

  // R7: the window opens only together with a pulse
  assert_window_needs_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(lockout) |-> press_pulse);

  // R4: the window lasts exactly HOLD_CYCLES cycles
  assert_window_length_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(lockout) && !$past(rst)) |-> (run_len == RW'(HOLD_CYCLES)));

  // R8: reset clears both outputs
  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (!press_pulse && !lockout));
endmodule

bind btn_press_pulser btn_press_pulser_chk #(.HOLD_CYCLES(HOLD_CYCLES)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .press_pulse (press_pulse),
  .lockout     (lockout)
);

// File: tb/test_btn_press_pulser.sv
module test_btn_press_pulser;
  localparam int HOLD = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_raw = 1'b0;
  logic press_pulse, lockout;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int npulse = 0;
  int ptime [4];
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  btn_press_pulser #(.HOLD_CYCLES(HOLD)) i_btn_press_pulser (
    .clk(clk), .rst(rst), .btn_raw(btn_raw),
    .press_pulse(press_pulse), .lockout(lockout)
  );

  always @(negedge clk) begin
    if (!rst && press_pulse) begin
      if (npulse < 4) ptime[npulse] = cyc;
      npulse = npulse + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic idle(input int n);
    btn_raw = 1'b0;
    repeat (n) @(negedge clk);
    npulse = 0;
  endtask

  // One-cycle press, then a second press d cycles later.
  task automatic sweep_case(input int d);
    int base;
    int exp_n;
    int bad_busy;
    bad_busy = 0;
    idle(HOLD + 6);
    btn_raw = 1'b1; base = cyc;
    @(negedge clk); btn_raw = 1'b0;
    while (cyc < base + d) begin
      if (cyc <= base + 3 + HOLD)
        if (lockout != ((cyc >= base + 3) && (cyc < base + 3 + HOLD))) bad_busy++;
      @(negedge clk);
    end
    btn_raw = 1'b1;
    while (cyc < base + d + HOLD + 6) begin
      if (cyc <= base + 3 + HOLD)
        if (lockout != ((cyc >= base + 3) && (cyc < base + 3 + HOLD))) bad_busy++;
      @(negedge clk);
    end
    btn_raw = 1'b0;
    exp_n = (d >= HOLD + 1) ? 2 : 1;
    check(npulse == exp_n, "R4 pulse count for spacing", npulse, exp_n);
    check(npulse >= 1 && ptime[0] == base + 3, "R1 R5 first pulse cycle",
          (npulse >= 1) ? ptime[0] - base : -1, 3);
    if (exp_n == 2)
      check(ptime[1] == base + d + 3, "R4 rearmed pulse cycle", ptime[1] - base, d + 3);
    check(bad_busy == 0, "R7 lockout window cycles", bad_busy, 0);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check(press_pulse == 1'b0, "R8 reset pulse", press_pulse, 0);
    check(lockout == 1'b0, "R8 reset lockout", lockout, 0);
    rst = 1'b0;

    for (int d = 2; d <= HOLD + 5; d++) sweep_case(d);

    // Bounce train ending inside the window, then held high past it.
    idle(HOLD + 6);
    base = cyc;
    for (int k = 0; k < HOLD - 1; k++) begin
      btn_raw = ~btn_raw;
      @(negedge clk);
    end
    btn_raw = 1'b1;
    wait_to(base + 3 * HOLD);
    check(npulse == 1, "R3 R6 bounce then hold", npulse, 1);
    check(lockout == 1'b0, "R6 window closed while held", lockout, 0);
    btn_raw = 1'b0;
    wait_to(base + 3 * HOLD + 4);
    btn_raw = 1'b1;
    wait_to(base + 3 * HOLD + 8);
    check(npulse == 2, "R4 fresh press after window", npulse, 2);
    btn_raw = 1'b0;

    // Reset in the middle of a window.
    idle(HOLD + 6);
    btn_raw = 1'b1; base = cyc;
    @(negedge clk); btn_raw = 1'b0;
    wait_to(base + 4);
    check(lockout == 1'b1, "R7 window open before reset", lockout, 1);
    rst = 1'b1;
    @(negedge clk);
    check(lockout == 1'b0, "R8 reset ends window", lockout, 0);
    check(press_pulse == 1'b0, "R8 reset clears pulse", press_pulse, 0);
    rst = 1'b0;
    npulse = 0;
    btn_raw = 1'b1; base = cyc;
    wait_to(base + 3);
    check(press_pulse == 1'b1, "R8 press accepted after reset", press_pulse, 1);
    @(negedge clk);
    check(press_pulse == 1'b0, "R2 pulse one cycle", press_pulse, 0);
    btn_raw = 1'b0;
    idle(HOLD + 4);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule